// File: doc/BRIEF.md
# Three-Port Universal Bus Exchanger

The exchanger connects three 18-bit ports, A, B and C, so that a word entering any port can be delivered to either or both of the other two. Each port keeps its own storage word. That word can follow the port's input bus, hold its value, or take in a new value on a rising edge of the port's own clock. The system clock samples the port clocks, so all capture happens synchronously.

Each port has a one-bit select that picks which of the other two ports feeds its output. A source in transparent mode passes its live input straight to the destination in the same cycle. A source in any other mode supplies its stored word. Output tristate is modelled with a separate output bus and a valid flag, so the design stays synthesizable. A port with its outputs enabled does not take in its own input bus.

Top module: `ubx_exchange`

## Requirements
- R1: While reset is asserted (rst_n low), all three storage words are 0 and every `*_dvalid` output is 0. After reset is released with all latch enables low, every output shows 0.
- R2: When a port's latch enable is 1 and its output enable `*_oe_n` is 1, its storage word is loaded from its input bus at every system clock edge. In that same cycle, any port selecting it shows that live input combinationally.
- R3: When a port's latch enable is 0 and its port clock stays at one level (high or low), its storage word keeps its value. This holds even while its input bus changes.
- R4: When latch enable is 0, a port clock that is 1 at a system clock edge after being 0 at the previous edge loads the input bus at that edge, and only at that edge.
- R5: `*_dvalid` equals the inverse of that port's `*_oe_n` (0 drives outputs, 1 means high impedance) whenever reset is not asserted.
- R6: Select mapping: for port A, sel 0 picks B and sel 1 picks C. For port B, sel 0 picks A and sel 1 picks C. For port C, sel 0 picks A and sel 1 picks B.
- R7: One source can feed both other ports at the same time, and both show the same word.
- R8: A port whose `*_oe_n` is 0 never loads its own input bus, and it never passes that bus through to other ports. Other ports see its stored word instead.
- R9: A source whose latch enable is 0 supplies its stored word to the ports selecting it, not its live input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_le | input | 1 | Port A latch enable (1 = transparent) |
| a_pclk | input | 1 | Port A capture clock, sampled by clk |
| a_sel | input | 1 | Port A source select |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_din | input | 18 | Port A input bus |
| a_dout | output | 18 | Port A output bus |
| a_dvalid | output | 1 | Port A output driven |
| b_le | input | 1 | Port B latch enable |
| b_pclk | input | 1 | Port B capture clock |
| b_sel | input | 1 | Port B source select |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_din | input | 18 | Port B input bus |
| b_dout | output | 18 | Port B output bus |
| b_dvalid | output | 1 | Port B output driven |
| c_le | input | 1 | Port C latch enable |
| c_pclk | input | 1 | Port C capture clock |
| c_sel | input | 1 | Port C source select |
| c_oe_n | input | 1 | Port C output enable, active low |
| c_din | input | 18 | Port C input bus |
| c_dout | output | 18 | Port C output bus |
| c_dvalid | output | 1 | Port C output driven |

## Verification
The live-versus-stored tests change a source's input right after its latch enable drops, which shows whether the destination tracks the bus or the stored word. Port-clock tests hold the clock high and then low while the data changes, and then give it a single low-to-high step. Together these separate level holding from edge capture, and show in which cycle the capture lands. Three distinct stored words, read through all six select settings, expose any swapped routing. A single source feeding two destinations, and a driving port given new data on its own bus, expose multicast faults and self-capture faults.

// File: rtl/ubx_pkg.sv
package ubx_pkg;
    localparam int NPORTS = 3;

    // Port-clock level seen at the previous system clock edge
    typedef enum logic {
        CLK_LO = 1'b0,
        CLK_HI = 1'b1
    } pclk_state_e;

    // Source index picked by a destination's select bit
    function automatic int src_of(input int dst, input logic sel);
        if (sel) return (dst == 2) ? 1 : 2;
        else     return (dst == 0) ? 1 : 0;
    endfunction
endpackage

// File: rtl/ubx_store.sv
module ubx_store
    import ubx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         pclk,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] live
);
    pclk_state_e state, state_nx;
    logic        rise;
    logic        load;

    // State register: remembers the port clock level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CLK_HI;
        else        state <= state_nx;
    end

    // Transitions and decoded actions
    always_comb begin
        state_nx = pclk ? CLK_HI : CLK_LO;
        rise     = 1'b0;
        unique case (state)
            CLK_LO: rise = pclk;
            CLK_HI: rise = 1'b0;
        endcase
        load = oe_n && (le || rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end

    // Combinational bypass when transparent and listening
    assign live = (le && oe_n) ? din : q;
endmodule

// File: rtl/ubx_route.sv
module ubx_route
    import ubx_pkg::*;
#(
    parameter int W   = 18,
    parameter int DST = 0
) (
    input  logic         rst_n,
    input  logic [W-1:0] src_val [NPORTS],
    input  logic         sel,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         dvalid
);
    localparam int SRC_LO = src_of(DST, 1'b0);
    localparam int SRC_HI = src_of(DST, 1'b1);

    assign dout   = sel ? src_val[SRC_HI] : src_val[SRC_LO];
    assign dvalid = rst_n && !oe_n;
endmodule

// File: rtl/ubx_exchange.sv
module ubx_exchange
    import ubx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_le,
    input  logic         a_pclk,
    input  logic         a_sel,
    input  logic         a_oe_n,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         a_dvalid,
    input  logic         b_le,
    input  logic         b_pclk,
    input  logic         b_sel,
    input  logic         b_oe_n,
    input  logic [W-1:0] b_din,
    output logic [W-1:0] b_dout,
    output logic         b_dvalid,
    input  logic         c_le,
    input  logic         c_pclk,
    input  logic         c_sel,
    input  logic         c_oe_n,
    input  logic [W-1:0] c_din,
    output logic [W-1:0] c_dout,
    output logic         c_dvalid
);
    logic         le_v     [NPORTS];
    logic         pclk_v   [NPORTS];
    logic         sel_v    [NPORTS];
    logic         oe_v     [NPORTS];
    logic [W-1:0] din_v    [NPORTS];
    logic [W-1:0] q_v      [NPORTS];
    logic [W-1:0] live_v   [NPORTS];
    logic [W-1:0] dout_v   [NPORTS];
    logic         dvalid_v [NPORTS];

    assign le_v   = '{a_le, b_le, c_le};
    assign pclk_v = '{a_pclk, b_pclk, c_pclk};
    assign sel_v  = '{a_sel, b_sel, c_sel};
    assign oe_v   = '{a_oe_n, b_oe_n, c_oe_n};
    assign din_v  = '{a_din, b_din, c_din};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ubx_store #(.W(W)) u_store (
            .clk  (clk),
            .rst_n(rst_n),
            .le   (le_v[p]),
            .pclk (pclk_v[p]),
            .oe_n (oe_v[p]),
            .din  (din_v[p]),
            .q    (q_v[p]),
            .live (live_v[p])
        );
        ubx_route #(.W(W), .DST(p)) u_route (
            .rst_n  (rst_n),
            .src_val(live_v),
            .sel    (sel_v[p]),
            .oe_n   (oe_v[p]),
            .dout   (dout_v[p]),
            .dvalid (dvalid_v[p])
        );
    end

    assign a_dout   = dout_v[0];
    assign b_dout   = dout_v[1];
    assign c_dout   = dout_v[2];
    assign a_dvalid = dvalid_v[0];
    assign b_dvalid = dvalid_v[1];
    assign c_dvalid = dvalid_v[2];
endmodule

// File: rtl/ubx_exchange_chk.sv
module ubx_exchange_chk
    import ubx_pkg::*;
#(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         le_v     [NPORTS],
    input logic         pclk_v   [NPORTS],
    input logic         oe_v     [NPORTS],
    input logic [W-1:0] din_v    [NPORTS],
    input logic [W-1:0] q_v      [NPORTS],
    input logic         dvalid_v [NPORTS]
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        logic prev_pclk;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_pclk <= 1'b1;
            else        prev_pclk <= pclk_v[p];
        end

        AST_TRANSP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (le_v[p] && oe_v[p]) |=> (q_v[p] == $past(din_v[p]))); // R2
        AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!le_v[p] && !(pclk_v[p] && !prev_pclk)) |=> $stable(q_v[p])); // R3
        AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_v[p] && !le_v[p] && pclk_v[p] && !prev_pclk) |=> (q_v[p] == $past(din_v[p]))); // R4
        AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            dvalid_v[p] == !oe_v[p]); // R5
        AST_DRIVER_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_v[p] |=> $stable(q_v[p])); // R8
    end
endmodule

bind ubx_exchange ubx_exchange_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_v    (le_v),
    .pclk_v  (pclk_v),
    .oe_v    (oe_v),
    .din_v   (din_v),
    .q_v     (q_v),
    .dvalid_v(dvalid_v)
);

// File: tb/ubx_exchange_test.sv
module ubx_exchange_test;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic         le_t   [3];
    logic         pclk_t [3];
    logic         sel_t  [3];
    logic         oe_t   [3];
    logic [W-1:0] din_t  [3];
    logic [W-1:0] dout_t [3];
    logic         val_t  [3];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ubx_exchange #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_le(le_t[0]), .a_pclk(pclk_t[0]), .a_sel(sel_t[0]), .a_oe_n(oe_t[0]),
        .a_din(din_t[0]), .a_dout(dout_t[0]), .a_dvalid(val_t[0]),
        .b_le(le_t[1]), .b_pclk(pclk_t[1]), .b_sel(sel_t[1]), .b_oe_n(oe_t[1]),
        .b_din(din_t[1]), .b_dout(dout_t[1]), .b_dvalid(val_t[1]),
        .c_le(le_t[2]), .c_pclk(pclk_t[2]), .c_sel(sel_t[2]), .c_oe_n(oe_t[2]),
        .c_din(din_t[2]), .c_dout(dout_t[2]), .c_dvalid(val_t[2])
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic test_reset();
        for (int p = 0; p < 3; p++) chk("R1 valid low", W'(val_t[p]), '0);
        for (int p = 0; p < 3; p++) chk("R1 stored zero sel0", dout_t[p], '0);
        for (int p = 0; p < 3; p++) sel_t[p] = 1'b1;
        #1;
        for (int p = 0; p < 3; p++) chk("R1 stored zero sel1", dout_t[p], '0);
        for (int p = 0; p < 3; p++) sel_t[p] = 1'b0;
    endtask

    task automatic test_transparent();
        @(negedge clk);
        le_t[1] = 1'b1; din_t[1] = 18'h01111; oe_t[0] = 1'b0; sel_t[0] = 1'b0;
        #1;
        chk("R2 bypass same cycle", dout_t[0], 18'h01111);
        chk("R5 valid when enabled", W'(val_t[0]), 18'd1);
        @(negedge clk);
        le_t[1] = 1'b0; din_t[1] = 18'h02222;
        #1;
        chk("R9 stored not live", dout_t[0], 18'h01111);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R3 hold clock low", dout_t[0], 18'h01111);
    endtask

    task automatic test_port_clock();
        @(negedge clk);
        din_t[1] = 18'h03333; pclk_t[1] = 1'b1;
        #1;
        chk("R4 no capture before edge", dout_t[0], 18'h01111);
        @(negedge clk);
        chk("R4 capture on rise", dout_t[0], 18'h03333);
        din_t[1] = 18'h04444;
        @(negedge clk); @(negedge clk);
        chk("R3 hold clock high", dout_t[0], 18'h03333);
        pclk_t[1] = 1'b0; din_t[1] = 18'h05555;
        @(negedge clk); @(negedge clk);
        chk("R4 no capture on fall", dout_t[0], 18'h03333);
    endtask

    task automatic test_select();
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin oe_t[p] = 1'b1; le_t[p] = 1'b1; end
        din_t[0] = 18'h00A1A; din_t[1] = 18'h00B2B; din_t[2] = 18'h00C3C;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin oe_t[p] = 1'b0; le_t[p] = 1'b0; sel_t[p] = 1'b0; end
        #1;
        chk("R6 A sel0 is B", dout_t[0], 18'h00B2B);
        chk("R6 B sel0 is A", dout_t[1], 18'h00A1A);
        chk("R6 C sel0 is A", dout_t[2], 18'h00A1A);
        for (int p = 0; p < 3; p++) sel_t[p] = 1'b1;
        #1;
        chk("R6 A sel1 is C", dout_t[0], 18'h00C3C);
        chk("R6 B sel1 is C", dout_t[1], 18'h00C3C);
        chk("R6 C sel1 is B", dout_t[2], 18'h00B2B);
    endtask

    task automatic test_multicast();
        @(negedge clk);
        oe_t[0] = 1'b1; le_t[0] = 1'b1; din_t[0] = 18'h15A5A;
        sel_t[1] = 1'b0; sel_t[2] = 1'b0;
        #1;
        chk("R7 B from A", dout_t[1], 18'h15A5A);
        chk("R7 C from A", dout_t[2], 18'h15A5A);
        chk("R5 A high impedance", W'(val_t[0]), '0);
    endtask

    task automatic test_own_bus();
        @(negedge clk);
        oe_t[0] = 1'b0; din_t[0] = 18'h2F0F0;
        #1;
        chk("R8 no passthrough from driver", dout_t[1], 18'h15A5A);
        chk("R5 A driven", W'(val_t[0]), 18'd1);
        @(negedge clk); @(negedge clk);
        chk("R8 driver keeps stored word", dout_t[2], 18'h15A5A);
        oe_t[2] = 1'b1;
        #1;
        chk("R5 C released", W'(val_t[2]), '0);
    endtask

    task automatic test_mid_reset();
        @(negedge clk);
        le_t[0] = 1'b0;
        for (int p = 0; p < 3; p++) oe_t[p] = 1'b0;
        rst_n = 1'b0;
        #1;
        for (int p = 0; p < 3; p++) chk("R1 valid low in reset", W'(val_t[p]), '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int p = 0; p < 3; p++) chk("R1 cleared after reset", dout_t[p], '0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int p = 0; p < 3; p++) begin
            le_t[p] = 1'b0; pclk_t[p] = 1'b0; sel_t[p] = 1'b0;
            oe_t[p] = 1'b1; din_t[p] = '0;
        end
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_transparent();
        test_port_clock();
        test_select();
        test_multicast();
        test_own_bus();
        test_mid_reset();
        summary();
    end
endmodule